// File: doc/BRIEF.md
# Accumulator Operate Unit

This block carries out the register-only instruction class of a 12-bit accumulator machine. The machine state it works on is 13 bits wide: a one-bit link `L` and a 12-bit accumulator `AC`. On a strobe it takes an instruction word, the present `L` and `AC`, and the 12-bit front-panel switch value. One clock later it presents the new `L` and `AC` together with a one-cycle done pulse.

A single word may ask for several micro-operations at once. The unit always applies them in the same order: clears first, then the switch OR, then the complements, then the increment, and the rotate last. The link is complemented whenever the increment carries out of the accumulator. The rotate moves the whole 13-bit value `{L, AC}` left by one place.

Word bits are numbered 0 (most significant) to 11 (least significant). In vector terms, word bit n is `instr[11-n]`.

Top module: `opr_unit`

## Requirements
- R1: After reset, `done` is 0, `lnk_out` is 0 and `acc_out` is 0.
- R2: A strobe is accepted only when word bits 0–2 equal octal 7 (`instr[11:9]==3'b111`). `done` is 1 in the cycle after an accepted strobe. After any other cycle `done` is 0.
- R3: With word bit 3 = 0 (group A): word bit 4 clears AC and word bit 5 clears L, before any other step.
- R4: In group A, word bit 6 complements AC and word bit 7 complements L, after the clears. So 7320 (octal) gives AC=0 and L=1, and 7240 gives AC=7777.
- R5: In group A, word bit 11 adds one to AC after the complements. A carry out of the AC MSB complements L. For example, 7001 on L=0, AC=7777 gives L=1, AC=0.
- R6: In group A, word bit 9 rotates `{L,AC}` left by one after the increment. The AC MSB goes into L, and L goes into the AC LSB. For example, 7004 on L=1, AC=4000 gives L=1, AC=0001.
- R7: With word bit 3 = 1 (group B): word bit 4 clears AC, and word bit 9 then ORs the switch value into AC. So 7604 gives AC equal to the switches. L is unchanged.
- R8: 7000 leaves L and AC unchanged. Word bits 8 and 10 in group A, and bits 5–8, 10 and 11 in group B, have no effect.
- R9: When no strobe is accepted, `lnk_out` and `acc_out` hold their values. A rejected word does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction strobe |
| instr | input | 12 | Instruction word |
| lnk_in | input | 1 | Present link bit |
| acc_in | input | 12 | Present accumulator |
| sw | input | 12 | Front-panel switch value |
| lnk_out | output | 1 | Resulting link bit |
| acc_out | output | 12 | Resulting accumulator |
| done | output | 1 | One-cycle result strobe |

## Verification
The increment and the rotate can fall in the same word. The carry out of the increment has to reach the link before the rotate moves the link into the accumulator. Directed words such as 7005 on AC=7777, and random group-A words with both bits set, provoke this case. Each result is judged against a bench model that applies the steps in the stated order.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int WORD_W  = 12;
  localparam int STATE_W = WORD_W + 1;

  // vector index of word bit n is WORD_W-1-n
  localparam int IX_GROUP = WORD_W - 1 - 3;
  localparam int IX_CLRA  = WORD_W - 1 - 4;
  localparam int IX_CLRL  = WORD_W - 1 - 5;
  localparam int IX_CMPA  = WORD_W - 1 - 6;
  localparam int IX_CMPL  = WORD_W - 1 - 7;
  localparam int IX_ROTL  = WORD_W - 1 - 9;
  localparam int IX_ORSW  = WORD_W - 1 - 9;
  localparam int IX_INCR  = WORD_W - 1 - 11;

  localparam logic [2:0] OPR_CLASS = 3'b111;

  typedef struct packed {
    logic clr_ac;
    logic clr_lk;
    logic or_sw;
    logic cmp_ac;
    logic cmp_lk;
    logic inc;
    logic rol;
  } uop_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output logic              valid,
  output uop_t              uop
);
  logic grp_b;

  always_comb begin
    valid      = (instr[WORD_W-1 -: 3] == OPR_CLASS);
    grp_b      = instr[IX_GROUP];
    uop        = '0;
    uop.clr_ac = instr[IX_CLRA];
    if (grp_b) begin
      uop.or_sw = instr[IX_ORSW];
    end else begin
      uop.clr_lk = instr[IX_CLRL];
      uop.cmp_ac = instr[IX_CMPA];
      uop.cmp_lk = instr[IX_CMPL];
      uop.inc    = instr[IX_INCR];
      uop.rol    = instr[IX_ROTL];
    end
  end
endmodule

// File: rtl/opr_alu.sv
module opr_alu
  import opr_pkg::*;
(
  input  uop_t              uop,
  input  logic              lnk_in,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] sw,
  output logic              lnk_res,
  output logic [WORD_W-1:0] acc_res
);
  logic [WORD_W-1:0] a_clr, a_or, a_cmp, a_inc;
  logic              l_clr, l_cmp, l_inc, carry;

  always_comb begin
    a_clr = uop.clr_ac ? '0 : acc_in;
    l_clr = uop.clr_lk ? 1'b0 : lnk_in;
    a_or  = uop.or_sw ? (a_clr | sw) : a_clr;
    a_cmp = uop.cmp_ac ? ~a_or : a_or;
    l_cmp = uop.cmp_lk ? ~l_clr : l_clr;
    {carry, a_inc} = {1'b0, a_cmp} + {{WORD_W{1'b0}}, uop.inc};
    l_inc = l_cmp ^ carry;
    if (uop.rol) begin
      lnk_res = a_inc[WORD_W-1];
      acc_res = {a_inc[WORD_W-2:0], l_inc};
    end else begin
      lnk_res = l_inc;
      acc_res = a_inc;
    end
  end

  always_comb begin
    if (uop.clr_ac && uop.cmp_ac && !uop.or_sw && !uop.inc && !uop.rol)
      AST_CLR_CMP_ONES: assert (acc_res == {WORD_W{1'b1}}); // R4
    if (uop.clr_ac && uop.or_sw)
      AST_SWITCH_LOAD: assert (acc_res == sw && lnk_res == lnk_in); // R7
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic              lnk_in,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] sw,
  output logic              lnk_out,
  output logic [WORD_W-1:0] acc_out,
  output logic              done
);
  uop_t              uop;
  logic              valid, accept;
  logic              lnk_res, lnk_d, done_d;
  logic [WORD_W-1:0] acc_res, acc_d;

  opr_decode u_dec (.instr(instr), .valid(valid), .uop(uop));

  opr_alu u_alu (
    .uop(uop), .lnk_in(lnk_in), .acc_in(acc_in), .sw(sw),
    .lnk_res(lnk_res), .acc_res(acc_res)
  );

  always_comb begin
    accept = start & valid;
    done_d = accept;
    lnk_d  = accept ? lnk_res : lnk_out;
    acc_d  = accept ? acc_res : acc_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lnk_out <= 1'b0;
      acc_out <= '0;
      done    <= 1'b0;
    end else begin
      lnk_out <= lnk_d;
      acc_out <= acc_d;
      done    <= done_d;
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && instr[WORD_W-1 -: 3] == OPR_CLASS) |=> done); // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && instr[WORD_W-1 -: 3] == OPR_CLASS) |=> !done); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(acc_out) && $stable(lnk_out)); // R9
endmodule

// File: tb/opr_unit_tb.sv
module opr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n, start, lnk_in, lnk_out, done;
  logic [11:0] instr, acc_in, sw, acc_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  opr_unit u_dut (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .lnk_in(lnk_in), .acc_in(acc_in), .sw(sw), .lnk_out(lnk_out),
    .acc_out(acc_out), .done(done));

  // reference model: returns {L, AC}
  function automatic logic [12:0] model(input logic [11:0] w, input logic l,
                                        input logic [11:0] a, input logic [11:0] s);
    logic [12:0] st;
    st = {l, a};
    if (w[7]) st[11:0] = 12'o0000;
    if (w[8]) begin
      if (w[2]) st[11:0] = st[11:0] | s;
    end else begin
      if (w[6]) st[12] = 1'b0;
      if (w[5]) st[11:0] = ~st[11:0];
      if (w[4]) st[12] = ~st[12];
      if (w[0]) st = {st[12] ^ (st[11:0] == 12'o7777), st[11:0] + 12'o1};
      if (w[2]) st = {st[11:0], st[12]};
    end
    return st;
  endfunction

  task automatic chk(input string req, input logic [12:0] got, input logic [12:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%o exp=%o", req, got, exp);
    end
  endtask

  logic        hl;
  logic [11:0] ha;

  task automatic run(input string req, input logic [11:0] w, input logic l,
                     input logic [11:0] a, input logic [11:0] s);
    logic ok;
    ok = (w[11:9] == 3'b111);
    @(negedge clk);
    start = 1'b1; instr = w; lnk_in = l; acc_in = a; sw = s;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, {12'd0, done}, {12'd0, ok});
    if (ok) begin
      chk(req, {lnk_out, acc_out}, model(w, l, a, s));
      hl = lnk_out; ha = acc_out;
    end else begin
      chk({req, " R9 reject"}, {lnk_out, acc_out}, {hl, ha});
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; instr = '0; lnk_in = 1'b0; acc_in = '0; sw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {lnk_out, acc_out}, 13'd0);
    chk("R1 done", {12'd0, done}, 13'd0);
    hl = 1'b0; ha = '0;

    run("R5", 12'o7001, 1'b0, 12'o7777, 12'o0);
    chk("R5 direct", {lnk_out, acc_out}, {1'b1, 12'o0000});
    run("R6", 12'o7004, 1'b1, 12'o4000, 12'o0);
    chk("R6 direct", {lnk_out, acc_out}, {1'b1, 12'o0001});
    run("R4", 12'o7320, 1'b0, 12'o1234, 12'o0);
    chk("R4 7320", {lnk_out, acc_out}, {1'b1, 12'o0000});
    run("R4", 12'o7240, 1'b0, 12'o0042, 12'o0);
    chk("R4 7240", {lnk_out, acc_out}, {1'b0, 12'o7777});
    run("R3", 12'o7300, 1'b1, 12'o5555, 12'o0);
    run("R7", 12'o7604, 1'b1, 12'o3333, 12'o2525);
    chk("R7 direct", {lnk_out, acc_out}, {1'b1, 12'o2525});
    run("R7 or", 12'o7404, 1'b0, 12'o1100, 12'o0011);
    run("R8", 12'o7000, 1'b1, 12'o4321, 12'o7777);
    chk("R8 nop", {lnk_out, acc_out}, {1'b1, 12'o4321});
    run("R8 ignored", 12'o7012, 1'b0, 12'o0707, 12'o7777);
    run("R5 R6 inc+rot", 12'o7005, 1'b0, 12'o7777, 12'o0);
    chk("R6 inc+rot direct", {lnk_out, acc_out}, {1'b0, 12'o0001});
    run("R2 reject", 12'o5001, 1'b1, 12'o1111, 12'o2222);

    @(negedge clk);
    chk("R9 idle", {lnk_out, acc_out}, {hl, ha});

    for (int i = 0; i < 400; i++) begin
      logic [11:0] w;
      w = 12'($urandom);
      if ($urandom_range(0, 4) != 0) w[11:9] = 3'b111;
      if ($urandom_range(0, 2) == 0) begin w[8] = 1'b0; w[2] = 1'b1; w[0] = 1'b1; end
      run("R2-rand", w, 1'($urandom), 12'($urandom), 12'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule